// File: doc/BRIEF.md
# Instruction Prefetch Queue Unit

This block is the front end of a processor pipeline. It covers the two fetch stages, a small first-in first-out instruction queue, and the handoff into the second decode stage. In its first fetch stage the unit places a word address on the program bus. In its second fetch stage, one cycle later, it captures the 32-bit word that the memory returns. Captured words wait in a four-entry queue. The back end pulls them out through a valid/ready handshake. Fetching does not depend on the back end: a stalled consumer only stops new addresses once the queue has no free slot, and an empty queue only idles the consumer.

Two kinds of control act on the front end. A redirect, for an interrupt or a program-flow change, throws away everything in the fetch and queue stages and restarts fetching at a new address. A word already accepted by the back end is never recalled. A speculative branch prefetch starts fetching at the branch target while the branch is still open. The target words are tagged and held inside the queue. On a taken outcome they are released in order. On a not-taken outcome they are dropped and fetching returns to the fall-through address.

Back-pressure rules at the outlet: `out_valid` may rise whenever the oldest queued word is untagged. While `out_ready` is low, the offered word and its address stay unchanged. A transfer happens in any cycle where both signals are high. `out_valid` can depend on `redirect_valid` in the same cycle. `fetch_req` can depend on `out_ready` in the same cycle, because a transfer out of a full queue frees a slot for an immediate fetch.

Top module: `fetch_front`

## Requirements
- R1: After reset the outlet is empty (`out_valid` low), and in the first cycle the unit fetches from the `RESET_VEC` parameter address with `fetch_req` high.
- R2: An address on `fetch_addr` with `fetch_req` high in cycle t is answered on `fetch_rdata` in cycle t+1. Without a redirect or speculation, successive fetch addresses increase by one, and each word leaves paired with the address it was fetched from.
- R3: With the outlet stalled from empty, exactly four fetches are issued, counting words still in flight. After that `fetch_req` stays low.
- R4: When the queue holds four words and a transfer out takes place, `fetch_req` is high in that same cycle.
- R5: Words leave in fetch order. While `out_valid` is high and `out_ready` is low, the next cycle shows the same word, unless a redirect arrives.
- R6: In a cycle with `redirect_valid` high, `out_valid` and `fetch_req` are low, and the queued and in-flight words are discarded. In the next cycle the unit fetches from `redirect_addr`.
- R7: A `spec_start` pulse, accepted when no speculation is open, redirects fetching to `spec_target`. The words fetched before the pulse are still delivered. The target words are not offered at the outlet while the branch is open.
- R8: `spec_resolve` with `spec_taken` high releases the held target words in order, starting at `spec_target`, right after the older words.
- R9: `spec_resolve` with `spec_taken` low drops the target words. Fetching resumes at the address following the last word fetched before `spec_start`, so the outlet stream continues with no gap.
- R10: A `spec_start` pulse while a speculation is open has no effect. The open speculation keeps its original target.
- R11: A redirect closes an open speculation. A later `spec_resolve` has no effect until a new `spec_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fetch_req | output | 1 | Fetch address valid this cycle |
| fetch_addr | output | 16 | Word address of the fetch |
| fetch_rdata | input | 32 | Word returned one cycle after the fetch |
| redirect_valid | input | 1 | Flush and restart fetch this cycle |
| redirect_addr | input | 16 | Restart address |
| spec_start | input | 1 | Open a speculative branch prefetch |
| spec_target | input | 16 | Branch target address |
| spec_resolve | input | 1 | Branch outcome known this cycle |
| spec_taken | input | 1 | Outcome: 1 taken, 0 not taken |
| out_valid | output | 1 | Word offered to decode stage 2 |
| out_ready | input | 1 | Decode stage 2 accepts the word |
| out_word | output | 32 | Offered instruction word |
| out_pc | output | 16 | Address of the offered word |

## Verification
Fetch issue and dequeue fall in the same cycle when the queue is full and the consumer accepts a word. The bench provokes this by stalling the outlet until four words sit in the queue, then raising `out_ready` for one cycle and requiring `fetch_req` high within that cycle. Redirect and a returning fetch or a pending transfer also collide. Random redirects under random back-pressure and random branch openings and outcomes provoke that case. A scoreboard judges it by requiring every transferred word to carry the expected next address, the restart address or the released branch target, with the matching word value.

// File: rtl/fetch_front_pkg.sv
package fetch_front_pkg;
  parameter int unsigned PC_W   = 16;
  parameter int unsigned WORD_W = 32;

  typedef logic [PC_W-1:0]   pc_t;
  typedef logic [WORD_W-1:0] word_t;

  // one queued instruction: fetch address, word, speculative tag
  typedef struct packed {
    pc_t   pc;
    word_t word;
    logic  spec;
  } qentry_t;
endpackage

// File: rtl/fetch_front_pcgen.sv
// First fetch stage: program counter, redirect and speculation control.
module fetch_front_pcgen
  import fetch_front_pkg::*;
#(
  parameter pc_t RESET_VEC = '0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic issue_ok,
  input  logic redirect_valid,
  input  pc_t  redirect_addr,
  input  logic spec_start,
  input  pc_t  spec_target,
  input  logic spec_resolve,
  input  logic spec_taken,
  output logic pa_req,
  output pc_t  pa_addr,
  output logic issue_spec,
  output logic squash_nt,
  output logic release_spec
);
  logic spec_mode_q;
  pc_t  pc_q;
  pc_t  ft_q;
  pc_t  pc_adv;
  logic start_ok;

  always_comb begin
    squash_nt    = spec_resolve && !spec_taken && spec_mode_q && !redirect_valid;
    release_spec = spec_resolve && spec_taken && spec_mode_q && !redirect_valid;
    start_ok     = spec_start && !spec_mode_q && !redirect_valid;
    pa_req       = issue_ok && !redirect_valid && !squash_nt;
    pa_addr      = pc_q;
    issue_spec   = spec_mode_q && !release_spec;
    pc_adv       = pc_q + pc_t'(pa_req);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q        <= RESET_VEC;
      ft_q        <= RESET_VEC;
      spec_mode_q <= 1'b0;
    end else if (redirect_valid) begin
      pc_q        <= redirect_addr;
      spec_mode_q <= 1'b0;
    end else if (squash_nt) begin
      pc_q        <= ft_q;
      spec_mode_q <= 1'b0;
    end else if (start_ok) begin
      ft_q        <= pc_adv;
      pc_q        <= spec_target;
      spec_mode_q <= 1'b1;
    end else begin
      pc_q <= pc_adv;
      if (release_spec) spec_mode_q <= 1'b0;
    end
  end

  // R9: after a not-taken outcome no further fetch carries the speculative tag
  a_r9_squash_ends_tag: assert property (@(posedge clk) disable iff (!rst_n)
    squash_nt |=> !issue_spec);
endmodule

// File: rtl/fetch_front_capture.sv
// Second fetch stage: holds the in-flight fetch and captures the returned word.
module fetch_front_capture
  import fetch_front_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    issue,
  input  logic    issue_spec,
  input  pc_t     pa_addr,
  input  word_t   prd_data,
  input  logic    kill,
  input  logic    squash,
  input  logic    release_spec,
  output logic    enq_valid,
  output qentry_t enq_entry,
  output logic    inflight
);
  logic v_q;
  logic spec_q;
  pc_t  pc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q    <= 1'b0;
      spec_q <= 1'b0;
      pc_q   <= '0;
    end else begin
      v_q    <= issue;
      spec_q <= issue_spec;
      pc_q   <= pa_addr;
    end
  end

  always_comb begin
    enq_valid      = v_q && !kill && !(squash && spec_q);
    enq_entry.pc   = pc_q;
    enq_entry.word = prd_data;
    enq_entry.spec = spec_q && !release_spec;
    inflight       = v_q;
  end

  // R6: a fetch issued under a redirect never returns a word
  a_r6_no_return_after_kill: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> !enq_valid);
endmodule

// File: rtl/fetch_front_queue.sv
// Circular instruction queue with speculative tagging. DEPTH: power of two, >= 2.
module fetch_front_queue
  import fetch_front_pkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    enq_valid,
  input  qentry_t enq_entry,
  input  logic    deq,
  input  logic    flush,
  input  logic    drop_spec,
  input  logic    clear_spec,
  output qentry_t head,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int unsigned PTR_W = $clog2(DEPTH);
  localparam int unsigned CNT_W = $clog2(DEPTH+1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  pc_t   pc_mem   [DEPTH];
  word_t word_mem [DEPTH];
  logic  spec_bits[DEPTH];

  logic [PTR_W-1:0] rd_q;
  logic [PTR_W-1:0] wr_idx;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] scnt_q;
  logic [CNT_W-1:0] keep_cnt;

  always_comb begin
    keep_cnt  = cnt_q - (drop_spec ? scnt_q : '0);
    wr_idx    = rd_q + PTR_W'(keep_cnt);
    head.pc   = pc_mem[rd_q];
    head.word = word_mem[rd_q];
    head.spec = spec_bits[rd_q];
    count     = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q   <= '0;
      cnt_q  <= '0;
      scnt_q <= '0;
    end else if (flush) begin
      rd_q   <= '0;
      cnt_q  <= '0;
      scnt_q <= '0;
    end else begin
      rd_q  <= rd_q + PTR_W'(deq);
      cnt_q <= keep_cnt - CNT_W'(deq) + CNT_W'(enq_valid);
      if (drop_spec || clear_spec) scnt_q <= '0;
      else scnt_q <= scnt_q + CNT_W'(enq_valid && enq_entry.spec);
    end
  end

  always_ff @(posedge clk) begin
    if (enq_valid && !flush) begin
      pc_mem[wr_idx]   <= enq_entry.pc;
      word_mem[wr_idx] <= enq_entry.word;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_tag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) spec_bits[i] <= 1'b0;
      else if (enq_valid && !flush && wr_idx == PTR_W'(i)) spec_bits[i] <= enq_entry.spec;
      else if (clear_spec) spec_bits[i] <= 1'b0;
    end
  end

  // R3: occupancy never exceeds the queue size
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL_CNT);
  // R4: a word may only enter a full queue when one leaves in the same cycle
  a_r4_full_enq_needs_deq: assert property (@(posedge clk) disable iff (!rst_n)
    (enq_valid && !flush && !drop_spec && cnt_q == FULL_CNT) |-> deq);
  // R7: a tagged word never leaves, and nothing leaves an empty queue
  a_r7_no_spec_dequeue: assert property (@(posedge clk) disable iff (!rst_n)
    deq |-> (!spec_bits[rd_q] && cnt_q != '0));
endmodule

// File: rtl/fetch_front.sv
// Instruction prefetch front end: fetch stages, queue, decode-2 handoff.
module fetch_front
  import fetch_front_pkg::*;
#(
  parameter int unsigned DEPTH     = 4,
  parameter pc_t         RESET_VEC = 16'h0100
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              fetch_req,
  output logic [PC_W-1:0]   fetch_addr,
  input  logic [WORD_W-1:0] fetch_rdata,
  input  logic              redirect_valid,
  input  logic [PC_W-1:0]   redirect_addr,
  input  logic              spec_start,
  input  logic [PC_W-1:0]   spec_target,
  input  logic              spec_resolve,
  input  logic              spec_taken,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_word,
  output logic [PC_W-1:0]   out_pc
);
  localparam int unsigned CNT_W = $clog2(DEPTH+1);
  localparam int unsigned OCC_W = CNT_W + 1;
  localparam logic [OCC_W-1:0] SLOTS = OCC_W'(DEPTH);

  logic             issue_ok;
  logic             issue_spec;
  logic             squash_nt;
  logic             release_spec;
  logic             enq_valid;
  qentry_t          enq_entry;
  logic             inflight;
  qentry_t          head;
  logic [CNT_W-1:0] count;
  logic [OCC_W-1:0] occ;
  logic             deq;

  always_comb begin
    occ       = {1'b0, count} + OCC_W'(inflight);
    out_valid = (count != '0) && !head.spec && !redirect_valid;
    deq       = out_valid && out_ready;
    issue_ok  = (occ < SLOTS) || ((occ == SLOTS) && deq);
    out_word  = head.word;
    out_pc    = head.pc;
  end

  fetch_front_pcgen #(.RESET_VEC(RESET_VEC)) u_pcgen (
    .clk(clk), .rst_n(rst_n), .issue_ok(issue_ok),
    .redirect_valid(redirect_valid), .redirect_addr(redirect_addr),
    .spec_start(spec_start), .spec_target(spec_target),
    .spec_resolve(spec_resolve), .spec_taken(spec_taken),
    .pa_req(fetch_req), .pa_addr(fetch_addr), .issue_spec(issue_spec),
    .squash_nt(squash_nt), .release_spec(release_spec)
  );

  fetch_front_capture u_capture (
    .clk(clk), .rst_n(rst_n), .issue(fetch_req), .issue_spec(issue_spec),
    .pa_addr(fetch_addr), .prd_data(fetch_rdata), .kill(redirect_valid),
    .squash(squash_nt), .release_spec(release_spec),
    .enq_valid(enq_valid), .enq_entry(enq_entry), .inflight(inflight)
  );

  fetch_front_queue #(.DEPTH(DEPTH)) u_queue (
    .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_entry(enq_entry),
    .deq(deq), .flush(redirect_valid), .drop_spec(squash_nt),
    .clear_spec(release_spec), .head(head), .count(count)
  );

  // R6: the queue is empty in the cycle after a redirect
  a_r6_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |=> !out_valid);
  // R6: fetching restarts at the redirect address one cycle later
  a_r6_redirect_target: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |=> (redirect_valid || (fetch_req && fetch_addr == $past(redirect_addr))));
endmodule

// File: tb/fetch_front_test.sv
module fetch_front_test;
  import fetch_front_pkg::*;

  localparam int  CLK_P = 10;
  localparam pc_t RVEC  = 16'h0100;

  logic  clk = 1'b0;
  logic  rst_n = 1'b0;
  logic  fetch_req;
  pc_t   fetch_addr;
  word_t fetch_rdata;
  logic  redirect_valid = 1'b0;
  pc_t   redirect_addr = '0;
  logic  spec_start = 1'b0;
  pc_t   spec_target = '0;
  logic  spec_resolve = 1'b0;
  logic  spec_taken = 1'b0;
  logic  out_valid;
  logic  out_ready = 1'b0;
  word_t out_word;
  pc_t   out_pc;

  always #(CLK_P/2) clk = ~clk;

  function automatic word_t word_of(pc_t a);
    return {a ^ 16'h5A3C, a};
  endfunction

  // program memory model: one cycle read latency
  pc_t mem_a = '0;
  always @(posedge clk) mem_a <= fetch_addr;
  assign fetch_rdata = word_of(mem_a);

  fetch_front #(.DEPTH(4), .RESET_VEC(RVEC)) uut (
    .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
    .fetch_rdata(fetch_rdata), .redirect_valid(redirect_valid),
    .redirect_addr(redirect_addr), .spec_start(spec_start),
    .spec_target(spec_target), .spec_resolve(spec_resolve),
    .spec_taken(spec_taken), .out_valid(out_valid), .out_ready(out_ready),
    .out_word(out_word), .out_pc(out_pc)
  );

  int  checks = 0;
  int  failures = 0;
  pc_t exp_pc = RVEC;
  bit  pending = 0, jump_ok = 0, prev_stall = 0, chk_redir = 0, fill_mode = 0;
  pc_t spec_tgt = '0, jump_tgt = '0, last_jump = '0, prev_pc = '0, redir_tgt = '0;
  int  hs_cnt = 0, fill_n = 0, hs0 = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic observe();
    bit pb;
    if (chk_redir && !redirect_valid)
      chk(fetch_req && fetch_addr == redir_tgt, "R6", "fetch after redirect",
          int'(fetch_addr), int'(redir_tgt));
    chk_redir = 0;
    if (prev_stall)
      chk(redirect_valid || (out_valid && out_pc == prev_pc), "R5",
          "word held under back-pressure", int'(out_pc), int'(prev_pc));
    if (fill_mode && fetch_req) begin
      chk(fetch_addr == RVEC + pc_t'(fill_n), "R2", "sequential fetch address",
          int'(fetch_addr), int'(RVEC + pc_t'(fill_n)));
      fill_n++;
    end
    if (redirect_valid) begin
      chk(!out_valid && !fetch_req, "R6", "quiet during redirect",
          int'({out_valid, fetch_req}), 0);
      exp_pc = redirect_addr; pending = 0; jump_ok = 0;
      chk_redir = 1; redir_tgt = redirect_addr;
    end else begin
      if (out_valid && out_ready) begin
        hs_cnt++;
        if (out_pc == exp_pc)
          chk(out_word == word_of(out_pc), "R2", "word matches address",
              int'(out_word), int'(word_of(out_pc)));
        else if (jump_ok && out_pc == jump_tgt) begin
          jump_ok = 0; last_jump = out_pc;
          chk(out_word == word_of(out_pc), "R8", "released target word",
              int'(out_word), int'(word_of(out_pc)));
        end else
          chk(1'b0, pending ? "R7" : (jump_ok ? "R8" : "R5"), "outlet order",
              int'(out_pc), int'(exp_pc));
        exp_pc = out_pc + 1'b1;
      end
      pb = pending;
      if (spec_resolve && pb) begin
        pending = 0;
        if (spec_taken) begin jump_ok = 1; jump_tgt = spec_tgt; end
      end
      if (spec_start && !pb) begin pending = 1; spec_tgt = spec_target; end
    end
    prev_stall = out_valid && !out_ready && !redirect_valid;
    prev_pc = out_pc;
  endtask

  task automatic samp(); #(CLK_P/2 - 1); observe(); endtask
  task automatic fin();  @(negedge clk); endtask
  task automatic cyc();  samp(); fin(); endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    #(CLK_P * 100000);
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state, R2/R3 fill with the outlet stalled
    fill_mode = 1; fill_n = 0;
    samp();
    chk(!out_valid, "R1", "outlet empty after reset", int'(out_valid), 0);
    chk(fetch_req && fetch_addr == RVEC, "R1", "first fetch at reset vector",
        int'(fetch_addr), int'(RVEC));
    fin();
    repeat (8) cyc();
    samp();
    chk(!fetch_req, "R3", "no fetch with queue full", int'(fetch_req), 0);
    chk(out_valid, "R5", "word offered while stalled", int'(out_valid), 1);
    fin();
    fill_mode = 0;
    chk(fill_n == 4, "R3", "fetches issued into stalled queue", fill_n, 4);

    // R4 transfer out of a full queue frees a slot in the same cycle
    out_ready = 1'b1;
    samp();
    chk(fetch_req && out_valid, "R4", "fetch alongside dequeue on full queue",
        int'({fetch_req, out_valid}), 3);
    chk(fetch_addr == RVEC + 16'd4, "R4", "next sequential address",
        int'(fetch_addr), int'(RVEC + 16'd4));
    fin();
    repeat (12) cyc();

    // R6 redirect
    redirect_valid = 1'b1; redirect_addr = 16'h4000;
    cyc();
    redirect_valid = 1'b0;
    repeat (10) cyc();

    // R7 hold, R9 not taken
    spec_start = 1'b1; spec_target = 16'h8000;
    cyc();
    spec_start = 1'b0;
    repeat (8) cyc();
    samp();
    chk(!out_valid, "R7", "target words held while open", int'(out_valid), 0);
    fin();
    hs0 = hs_cnt;
    spec_resolve = 1'b1; spec_taken = 1'b0;
    cyc();
    spec_resolve = 1'b0;
    repeat (10) cyc();
    chk(hs_cnt - hs0 >= 6, "R9", "fall-through stream resumes", hs_cnt - hs0, 6);

    // R8 taken, R10 second start ignored
    out_ready = 1'b0;
    spec_start = 1'b1; spec_target = 16'hA000;
    cyc();
    spec_target = 16'hC000;
    cyc();
    spec_start = 1'b0;
    repeat (3) cyc();
    spec_resolve = 1'b1; spec_taken = 1'b1;
    cyc();
    spec_resolve = 1'b0; out_ready = 1'b1;
    repeat (15) cyc();
    chk(!jump_ok && last_jump == 16'hA000, "R8", "target released in order",
        int'(last_jump), 32'hA000);
    chk(last_jump != 16'hC000, "R10", "second start left no trace",
        int'(last_jump), 32'hA000);

    // R11 redirect closes speculation
    spec_start = 1'b1; spec_target = 16'hE000;
    cyc();
    spec_start = 1'b0;
    repeat (2) cyc();
    redirect_valid = 1'b1; redirect_addr = 16'h2000;
    cyc();
    redirect_valid = 1'b0; spec_resolve = 1'b1; spec_taken = 1'b1;
    cyc();
    spec_resolve = 1'b0;
    hs0 = hs_cnt;
    repeat (10) cyc();
    chk(hs_cnt - hs0 >= 6 && last_jump == 16'hA000, "R11",
        "stale resolve ignored after redirect", hs_cnt - hs0, 6);

    // constrained random mix
    for (int i = 0; i < 4000; i++) begin
      out_ready      = ($urandom % 10) < 7;
      redirect_valid = ($urandom % 60) == 0;
      redirect_addr  = pc_t'($urandom);
      spec_start     = !jump_ok && (($urandom % 25) == 0);
      spec_target    = pc_t'($urandom);
      spec_resolve   = ($urandom % 20) == 0;
      spec_taken     = ($urandom % 2) == 1;
      cyc();
    end
    redirect_valid = 1'b0; spec_start = 1'b0; spec_resolve = 1'b0;
    repeat (4) cyc();

    summary();
    $finish;
  end
endmodule